// File: doc/BRIEF.md
# Receive descriptor ownership sequencer

This block is the control state machine that decides where an incoming network frame goes in a ring of host receive descriptors. It keeps two cached ownership bits, one for the current descriptor and one for the following descriptor, and a single ring index. Descriptor status words are read and written through a single-beat request port that has one access outstanding at a time. The host can trigger a demand poll. Polling is skipped while both cached bits already show controller ownership.

When a frame arrives, the sequencer waits for the address-filter verdict. It then confirms ownership of the current buffer, making one final retry read if the cache says the host still holds it. If both fail, it counts a missed frame. It then walks the frame across chained buffers, handing each full buffer back by clearing only its ownership bit, and it looks ahead one descriptor after every handover. At frame end it writes the end-of-packet status word with the total byte count, or a buffer-error word if data had to be dropped, and it advances the ring. The data path itself is reduced to a byte valid/ready strobe and a store indication.

Top module: `rxd_own_seq`

## Requirements
- R1: After synchronous reset, `mem_req_o`, `byte_rdy_o` and `miss_o` are 0, `miss_cnt_o` is 0, and the current descriptor index is 0.
- R2: A `poll_i` pulse in the idle state reads the current descriptor. If the returned ownership bit (status word bit 31) is 1, it then reads the next descriptor. If the current descriptor is not owned, exactly one read is made. When both cached bits show ownership, `poll_i` causes no access.
- R3: After `frm_start_i`, no descriptor access happens until `filt_vld_i`. A rejected frame (`filt_acc_i`=0) causes no access, and its bytes are drained with `byte_rdy_o`=1 and `byte_store_o`=0 until `frm_end_i`.
- R4: An accepted frame whose cached current bit is 0 gets one read of the current descriptor. If that read returns bit 31 = 0, `miss_o` pulses for one cycle and `miss_cnt_o` rises by one. No further access happens until the frame ends, and `poll_i` is ignored.
- R5: With the current descriptor owned, the next descriptor is read unless its cached bit is already 1. Bytes are then stored (`byte_store_o`=1) into the current buffer whatever that read returned.
- R6: If a byte arrives while the buffer already holds `buf_len_i` bytes and the next descriptor is not owned, that byte and the rest are discarded. At frame end the current descriptor is written with full mask and data 0x3000_0000: bit 31 (own) 0, bit 30 (end) 0, bit 29 (buffer error) 1, bit 28 (overflow) 1, count 0.
- R7: If that byte arrives and the next descriptor is owned, the byte is stalled (`byte_rdy_o`=0). The current descriptor is written with mask 0x8000_0000 and data 0. The descriptor after the new current one is then read, and storing resumes in the new buffer with its count reset.
- R8: At normal frame end the current descriptor is written with full mask, bit 31 = 0, bit 30 (end) = 1 and bits 15:0 = total bytes of the frame. The next descriptor then becomes current, keeping its cached ownership. Every descriptor write carries bit 31 = 0.
- R9: The descriptor index after `ring_len_i`-1 is 0.
- R10: A request keeps `mem_req_o`, `mem_idx_o` and `mem_we_o` stable until `mem_ack_i`, and only one access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_len_i | input | IDX_W+1 | Number of descriptors in the ring |
| buf_len_i | input | LEN_W | Byte capacity of each buffer |
| poll_i | input | 1 | Demand poll request |
| frm_start_i | input | 1 | Frame start strobe |
| filt_vld_i | input | 1 | Address filter verdict valid |
| filt_acc_i | input | 1 | Frame accepted by the filters |
| byte_vld_i | input | 1 | A frame byte is offered |
| byte_rdy_o | output | 1 | Offered byte is taken this cycle |
| byte_store_o | output | 1 | Taken byte goes into the current buffer |
| frm_end_i | input | 1 | Last byte of the frame has been taken |
| mem_req_o | output | 1 | Descriptor access request |
| mem_we_o | output | 1 | Access is a write |
| mem_idx_o | output | IDX_W | Descriptor index |
| mem_wdata_o | output | 32 | Status word to write |
| mem_wmask_o | output | 32 | Bit mask of the write |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rd_own_i | input | 1 | Ownership bit of the word read |
| miss_o | output | 1 | One-cycle missed-frame pulse |
| miss_cnt_o | output | MISS_W | Missed-frame count |

## Verification
The hardest case is a frame that rolls over into an owned second buffer and then overflows it because the lookahead found the third descriptor still held by the host. Only then do the own-only handover, the lookahead read and the buffer-error close all land in one frame. The bench reaches it by loading an ownership pattern into its memory model after a reset, sending more bytes than two buffers hold, and checking every descriptor word and the count of accesses afterwards. The memory model's response latency varies between vectors, so every wait state and the request-hold rule are exercised.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int WORD_W   = 32;
    localparam int OWN_BIT  = 31;
    localparam int MCNT_W   = 16;

    typedef enum logic [3:0] {
        S_IDLE, S_PCUR, S_PNXT, S_WFILT, S_FCUR, S_FNXT,
        S_XFER, S_RET, S_LOOK, S_OVF, S_DROP, S_CLOSE
    } seq_state_e;

    typedef struct packed {
        logic              own;
        logic              enp;
        logic              buff;
        logic              oflo;
        logic [11:0]       rsvd;
        logic [MCNT_W-1:0] mcnt;
    } rx_stat_t;

    function automatic logic [WORD_W-1:0] close_word(input logic err,
                                                     input logic [MCNT_W-1:0] cnt);
        rx_stat_t w;
        w      = '0;
        w.enp  = !err;
        w.buff = err;
        w.oflo = err;
        w.mcnt = err ? '0 : cnt;
        return w;
    endfunction
endpackage

// File: rtl/rxd_ring_cache.sv
module rxd_ring_cache #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W:0]   ring_len,
    input  logic             cur_set,
    input  logic             nxt_wr,
    input  logic             nxt_val,
    input  logic             adv,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             cur_own,
    output logic             nxt_own
);
    logic [IDX_W-1:0] cur_q;
    logic             cur_own_q, nxt_own_q;
    logic [IDX_W:0]   inc;

    assign inc     = {1'b0, cur_q} + 1'b1;
    assign nxt_idx = (inc >= ring_len) ? '0 : inc[IDX_W-1:0];
    assign cur_idx = cur_q;
    assign cur_own = cur_own_q;
    assign nxt_own = nxt_own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            cur_own_q <= 1'b0;
            nxt_own_q <= 1'b0;
        end else if (adv) begin
            cur_q     <= nxt_idx;
            cur_own_q <= nxt_own_q;
            nxt_own_q <= 1'b0;
        end else begin
            if (cur_set) cur_own_q <= 1'b1;
            if (nxt_wr)  nxt_own_q <= nxt_val;
        end
    end

    // R9
    ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && ring_len != '0 && $stable(ring_len)) |=> ({1'b0, cur_idx} < ring_len));
endmodule

// File: rtl/rxd_byte_cnt.sv
module rxd_byte_cnt #(
    parameter int LEN_W  = 8,
    parameter int MCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              roll,
    input  logic              store,
    input  logic [LEN_W-1:0]  buf_len,
    output logic              buf_full,
    output logic [MCNT_W-1:0] mcnt
);
    logic [LEN_W-1:0]  bcnt_q;
    logic [MCNT_W-1:0] mcnt_q;

    assign buf_full = (bcnt_q >= buf_len);
    assign mcnt     = mcnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bcnt_q <= '0;
            mcnt_q <= '0;
        end else begin
            if (roll)       bcnt_q <= '0;
            else if (store) bcnt_q <= bcnt_q + 1'b1;
            if (store)      mcnt_q <= mcnt_q + 1'b1;
        end
    end

    // R6
    buf_bound_chk: assert property (@(posedge clk) disable iff (rst)
        store |-> (bcnt_q < buf_len));
endmodule

// File: rtl/rxd_own_seq.sv
module rxd_own_seq
    import rxd_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int LEN_W  = 8,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W:0]    ring_len_i,
    input  logic [LEN_W-1:0]  buf_len_i,
    input  logic              poll_i,
    input  logic              frm_start_i,
    input  logic              filt_vld_i,
    input  logic              filt_acc_i,
    input  logic              byte_vld_i,
    output logic              byte_rdy_o,
    output logic              byte_store_o,
    input  logic              frm_end_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [IDX_W-1:0]  mem_idx_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic [WORD_W-1:0] mem_wmask_o,
    input  logic              mem_ack_i,
    input  logic              mem_rd_own_i,
    output logic              miss_o,
    output logic [MISS_W-1:0] miss_cnt_o
);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;

    seq_state_e        st_q, st_d;
    logic [IDX_W-1:0]  cur_idx, nxt_idx;
    logic              cur_own, nxt_own;
    logic              cur_set, nxt_wr, adv;
    logic              buf_full, cnt_clr, cnt_roll, store;
    logic [MCNT_W-1:0] mcnt;
    logic              ovf_q, ovf_set, miss_set, miss_q, ack;
    logic [MISS_W-1:0] miss_cnt_q;

    assign ack = mem_req_o & mem_ack_i;

    rxd_ring_cache #(.IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst(rst), .ring_len(ring_len_i),
        .cur_set(cur_set), .nxt_wr(nxt_wr), .nxt_val(mem_rd_own_i), .adv(adv),
        .cur_idx(cur_idx), .nxt_idx(nxt_idx), .cur_own(cur_own), .nxt_own(nxt_own)
    );

    rxd_byte_cnt #(.LEN_W(LEN_W), .MCNT_W(MCNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .roll(cnt_roll), .store(store),
        .buf_len(buf_len_i), .buf_full(buf_full), .mcnt(mcnt)
    );

    // descriptor access port, decoded from the state
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_idx_o   = cur_idx;
        mem_wdata_o = '0;
        mem_wmask_o = '0;
        unique case (st_q)
            S_PCUR, S_FCUR: mem_req_o = 1'b1;
            S_PNXT, S_FNXT, S_LOOK: begin
                mem_req_o = 1'b1;
                mem_idx_o = nxt_idx;
            end
            S_RET: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wmask_o = OWN_MASK;
            end
            S_CLOSE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wmask_o = '1;
                mem_wdata_o = close_word(ovf_q, mcnt);
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (st_q)
            S_XFER:        byte_rdy_o = !(buf_full && nxt_own);
            S_OVF, S_DROP: byte_rdy_o = 1'b1;
            default:       byte_rdy_o = 1'b0;
        endcase
    end

    assign store        = (st_q == S_XFER) && byte_vld_i && !buf_full;
    assign byte_store_o = store;

    always_comb begin
        st_d     = st_q;
        cur_set  = 1'b0;
        nxt_wr   = 1'b0;
        adv      = 1'b0;
        cnt_clr  = 1'b0;
        cnt_roll = 1'b0;
        ovf_set  = 1'b0;
        miss_set = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (frm_start_i) begin
                    st_d    = S_WFILT;
                    cnt_clr = 1'b1;
                end else if (poll_i) begin
                    if (!cur_own)      st_d = S_PCUR;
                    else if (!nxt_own) st_d = S_PNXT;
                end
            end
            S_PCUR: if (ack) begin
                if (mem_rd_own_i) begin
                    cur_set = 1'b1;
                    st_d    = nxt_own ? S_IDLE : S_PNXT;
                end else begin
                    st_d = S_IDLE;
                end
            end
            S_PNXT: if (ack) begin
                nxt_wr = 1'b1;
                st_d   = S_IDLE;
            end
            S_WFILT: if (filt_vld_i) begin
                if (!filt_acc_i)   st_d = S_DROP;
                else if (!cur_own) st_d = S_FCUR;
                else if (!nxt_own) st_d = S_FNXT;
                else               st_d = S_XFER;
            end
            S_FCUR: if (ack) begin
                if (mem_rd_own_i) begin
                    cur_set = 1'b1;
                    st_d    = nxt_own ? S_XFER : S_FNXT;
                end else begin
                    miss_set = 1'b1;
                    st_d     = S_DROP;
                end
            end
            S_FNXT: if (ack) begin
                nxt_wr = 1'b1;
                st_d   = S_XFER;
            end
            S_XFER: begin
                if (frm_end_i) begin
                    st_d = S_CLOSE;
                end else if (byte_vld_i && buf_full) begin
                    if (nxt_own) begin
                        st_d = S_RET;
                    end else begin
                        ovf_set = 1'b1;
                        st_d    = S_OVF;
                    end
                end
            end
            S_RET: if (ack) begin
                adv      = 1'b1;
                cnt_roll = 1'b1;
                st_d     = S_LOOK;
            end
            S_LOOK: if (ack) begin
                nxt_wr = 1'b1;
                st_d   = S_XFER;
            end
            S_OVF:  if (frm_end_i) st_d = S_CLOSE;
            S_DROP: if (frm_end_i) st_d = S_IDLE;
            S_CLOSE: if (ack) begin
                adv  = 1'b1;
                st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            ovf_q      <= 1'b0;
            miss_q     <= 1'b0;
            miss_cnt_q <= '0;
        end else begin
            st_q   <= st_d;
            miss_q <= miss_set;
            if (cnt_clr)      ovf_q <= 1'b0;
            else if (ovf_set) ovf_q <= 1'b1;
            if (miss_set) miss_cnt_q <= miss_cnt_q + 1'b1;
        end
    end

    assign miss_o     = miss_q;
    assign miss_cnt_o = miss_cnt_q;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_idx_o) && $stable(mem_we_o)));

    // R8
    give_back_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |-> !mem_wdata_o[OWN_BIT]);

    // R2
    cached_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && poll_i && !frm_start_i && cur_own && nxt_own) |=> !mem_req_o);

    // R4
    miss_count_chk: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> (miss_cnt_o == $past(miss_cnt_o) + 1'b1));

    // R7
    stall_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld_i && buf_full && nxt_own && st_q == S_XFER && !frm_end_i) |-> !byte_rdy_o);
endmodule

// File: tb/rxd_own_seq_tb.sv
`timescale 1ns/1ps
module rxd_own_seq_tb;
    localparam int IDX_W = 4;
    localparam int LEN_W = 8;
    localparam int MISS_W = 16;

    typedef struct packed {
        logic [3:0]  own;
        logic        acc;
        logic [7:0]  nbyt;
        logic [7:0]  blen;
        logic [7:0]  exp_store;
        logic [3:0]  exp_nacc;
        logic        exp_miss;
        logic [31:0] s0;
        logic [31:0] s1;
        logic [31:0] s2;
    } vec_t;

    // V0 R5/R8 plain frame, V1 R4 miss, V2 R6 overflow, V3 R7 rollover,
    // V4 R3 reject, V5 R8 exact fill, V6 R7 double rollover, V7 R6+R7
    localparam vec_t VECS [8] = '{
        '{4'b0011, 1'b1, 8'd5,  8'd8, 8'd5,  4'd3, 1'b0, 32'h4000_0005, 32'h8000_0000, 32'h0},
        '{4'b0000, 1'b1, 8'd5,  8'd8, 8'd0,  4'd1, 1'b1, 32'h0,         32'h0,         32'h0},
        '{4'b0001, 1'b1, 8'd10, 8'd6, 8'd6,  4'd3, 1'b0, 32'h3000_0000, 32'h0,         32'h0},
        '{4'b0111, 1'b1, 8'd10, 8'd8, 8'd10, 4'd5, 1'b0, 32'h0,         32'h4000_000A, 32'h8000_0000},
        '{4'b0011, 1'b0, 8'd6,  8'd8, 8'd0,  4'd0, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'h0},
        '{4'b0011, 1'b1, 8'd8,  8'd8, 8'd8,  4'd3, 1'b0, 32'h4000_0008, 32'h8000_0000, 32'h0},
        '{4'b1111, 1'b1, 8'd20, 8'd8, 8'd20, 4'd7, 1'b0, 32'h0,         32'h0,         32'h4000_0014},
        '{4'b0011, 1'b1, 8'd17, 8'd8, 8'd16, 4'd5, 1'b0, 32'h0,         32'h3000_0000, 32'h0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IDX_W:0] ring_len_i = 5'd4;
    logic [LEN_W-1:0] buf_len_i = 8'd8;
    logic poll_i = 0, frm_start_i = 0, filt_vld_i = 0, filt_acc_i = 0;
    logic byte_vld_i = 0, frm_end_i = 0, mem_ack_i = 0, mem_rd_own_i = 0;
    logic byte_rdy_o, byte_store_o, mem_req_o, mem_we_o, miss_o;
    logic [IDX_W-1:0] mem_idx_o;
    logic [31:0] mem_wdata_o, mem_wmask_o;
    logic [MISS_W-1:0] miss_cnt_o;

    always #2 clk = ~clk;

    rxd_own_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W), .MISS_W(MISS_W)) u_dut (
        .clk(clk), .rst(rst), .ring_len_i(ring_len_i), .buf_len_i(buf_len_i),
        .poll_i(poll_i), .frm_start_i(frm_start_i), .filt_vld_i(filt_vld_i),
        .filt_acc_i(filt_acc_i), .byte_vld_i(byte_vld_i), .byte_rdy_o(byte_rdy_o),
        .byte_store_o(byte_store_o), .frm_end_i(frm_end_i), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_idx_o(mem_idx_o), .mem_wdata_o(mem_wdata_o),
        .mem_wmask_o(mem_wmask_o), .mem_ack_i(mem_ack_i), .mem_rd_own_i(mem_rd_own_i),
        .miss_o(miss_o), .miss_cnt_o(miss_cnt_o)
    );

    int total = 0, bad = 0;
    logic [31:0] stat_tb [16];
    int log_idx [64];
    int log_we [64];
    int acc_n = 0, miss_seen = 0, hold_bad = 0, lat = 0, wcnt = 0;
    int last_wr_idx = -1, last_rd_idx = -1;
    bit hold_pend = 0;
    int hold_idx = 0;
    bit hold_we = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // host memory model: answers each request after lat idle cycles
    task automatic responder();
        forever begin
            @(negedge clk);
            if (hold_pend && !(mem_req_o && int'(mem_idx_o) == hold_idx && mem_we_o == hold_we))
                hold_bad++;
            hold_pend = 0;
            if (rst) begin
                mem_ack_i = 0; wcnt = 0; acc_n = 0; miss_seen = 0;
            end else begin
                if (miss_o) miss_seen++;
                if (mem_ack_i) begin
                    mem_ack_i = 0;
                end else if (mem_req_o) begin
                    if (wcnt >= lat) begin
                        mem_ack_i = 1;
                        wcnt = 0;
                        mem_rd_own_i = stat_tb[mem_idx_o][31];
                        if (mem_we_o) begin
                            stat_tb[mem_idx_o] = (stat_tb[mem_idx_o] & ~mem_wmask_o) |
                                                 (mem_wdata_o & mem_wmask_o);
                            last_wr_idx = int'(mem_idx_o);
                        end else begin
                            last_rd_idx = int'(mem_idx_o);
                        end
                        if (acc_n < 64) begin
                            log_idx[acc_n] = int'(mem_idx_o);
                            log_we[acc_n] = int'(mem_we_o);
                        end
                        acc_n++;
                    end else begin
                        wcnt++;
                        hold_pend = 1;
                        hold_idx = int'(mem_idx_o);
                        hold_we = mem_we_o;
                    end
                end
            end
        end
    endtask

    task automatic watchdog();
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic run_frame(input bit acc, input int n, output int stored, output int pre_acc);
        @(negedge clk); frm_start_i = 1;
        @(negedge clk); frm_start_i = 0;
        repeat (3) @(negedge clk);
        pre_acc = acc_n;
        filt_vld_i = 1; filt_acc_i = acc;
        @(negedge clk); filt_vld_i = 0;
        stored = 0;
        for (int i = 0; i < n; i++) begin
            byte_vld_i = 1;
            #1;
            while (!byte_rdy_o) begin
                @(negedge clk);
                #1;
            end
            if (byte_store_o) stored++;
            poll_i = (i == 1);
            @(negedge clk);
        end
        byte_vld_i = 0; poll_i = 0;
        frm_end_i = 1;
        @(negedge clk); frm_end_i = 0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int st, pa, base;
        fork
            responder();
            watchdog();
        join_none
        for (int k = 0; k < 16; k++) stat_tb[k] = 32'h0;
        do_reset();
        #1;
        // R1 reset state
        chk(mem_req_o == 0 && byte_rdy_o == 0 && miss_o == 0, "R1", {29'd0, mem_req_o, byte_rdy_o, miss_o}, 32'h0);
        chk(miss_cnt_o == 0, "R1", 32'(miss_cnt_o), 32'h0);

        // vector table
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < 16; k++) stat_tb[k] = (k < 4 && VECS[v].own[k]) ? 32'h8000_0000 : 32'h0;
            buf_len_i = VECS[v].blen;
            lat = v % 3;
            do_reset();
            run_frame(VECS[v].acc, int'(VECS[v].nbyt), st, pa);
            chk(pa == 0, "R3", 32'(pa), 32'h0);
            chk(st == int'(VECS[v].exp_store), "R5/R6/R7 stored", 32'(st), 32'(VECS[v].exp_store));
            chk(acc_n == int'(VECS[v].exp_nacc), "R2/R4 accesses", 32'(acc_n), 32'(VECS[v].exp_nacc));
            chk(stat_tb[0] == VECS[v].s0, "R6/R8 desc0", stat_tb[0], VECS[v].s0);
            chk(stat_tb[1] == VECS[v].s1, "R7/R8 desc1", stat_tb[1], VECS[v].s1);
            chk(stat_tb[2] == VECS[v].s2, "R7/R8 desc2", stat_tb[2], VECS[v].s2);
            chk(miss_seen == int'(VECS[v].exp_miss) && miss_cnt_o == MISS_W'(VECS[v].exp_miss),
                "R4 miss", 32'(miss_cnt_o), 32'(VECS[v].exp_miss));
        end

        // R2 demand poll and caching
        lat = 1;
        buf_len_i = 8'd8;
        for (int k = 0; k < 16; k++) stat_tb[k] = 32'h0;
        stat_tb[0] = 32'h8000_0000; stat_tb[1] = 32'h8000_0000;
        do_reset();
        poll_i = 1; @(negedge clk); poll_i = 0;
        repeat (12) @(negedge clk);
        chk(acc_n == 2 && log_idx[0] == 0 && log_idx[1] == 1, "R2 poll pair", 32'(acc_n), 32'd2);
        poll_i = 1; @(negedge clk); poll_i = 0;
        repeat (12) @(negedge clk);
        chk(acc_n == 2, "R2 cached skip", 32'(acc_n), 32'd2);
        // R5 cached bits: the frame goes straight to data, then R8 advance
        run_frame(1'b1, 3, st, pa);
        chk(acc_n == 3 && log_we[2] == 1 && log_idx[2] == 0, "R5 no repoll", 32'(acc_n), 32'd3);
        chk(stat_tb[0] == 32'h4000_0003, "R8 end word", stat_tb[0], 32'h4000_0003);
        run_frame(1'b1, 2, st, pa);
        chk(log_idx[3] == 2 && log_we[3] == 0 && log_idx[4] == 1 && log_we[4] == 1,
            "R8 next becomes current", 32'(log_idx[4]), 32'd1);
        chk(stat_tb[1] == 32'h4000_0002, "R8 second frame", stat_tb[1], 32'h4000_0002);

        for (int k = 0; k < 16; k++) stat_tb[k] = 32'h0;
        do_reset();
        poll_i = 1; @(negedge clk); poll_i = 0;
        repeat (12) @(negedge clk);
        chk(acc_n == 1, "R2 single read", 32'(acc_n), 32'd1);

        // R9 ring wrap with three descriptors, host refills after each frame
        ring_len_i = 5'd3;
        lat = 0;
        for (int k = 0; k < 16; k++) stat_tb[k] = 32'h8000_0000;
        do_reset();
        for (int f = 0; f < 4; f++) begin
            base = acc_n;
            run_frame(1'b1, 2, st, pa);
            chk(last_wr_idx == (f % 3), "R9 close index", 32'(last_wr_idx), 32'(f % 3));
            if (f == 2) chk(last_rd_idx == 0, "R9 lookahead wraps", 32'(last_rd_idx), 32'd0);
            stat_tb[last_wr_idx] = 32'h8000_0000;
        end

        // R10 request stability across all waits
        chk(hold_bad == 0, "R10 hold", 32'(hold_bad), 32'd0);

        summary();
        $finish;
    end
endmodule